// File: doc/BRIEF.md
# Serial Programming Command Target

This block is the device side of a four-byte serial programming link. A host holds the active-low enable input low and clocks command bytes in over a serial data line, most significant bit first. The block samples the data on rising serial clock edges and updates its serial output on falling edges. It decodes each complete four-byte frame and answers on the serial output. The serial pins are brought into the system clock domain by two-flop synchronisers, so the serial clock must stay well below the system clock: each half period should last at least six system clock cycles.

After the enable goes low, the block acts only on the programming-enable frame. Once that frame has been accepted, it also decodes chip erase, a ready/busy poll, loads of the page buffer's low and high bytes, page write, the extended (upper) address byte, program-memory reads and data-EEPROM writes and reads. Writes and erases go out on a memory request port, one operation per cycle, and the block stays busy for a parameterised number of cycles afterwards. A write or erase that arrives while the block is busy is discarded and sets a sticky error flag. The host reads this flag through the poll frame.

Command codes (first byte): enable / chip erase 0xAC, poll 0xF0, load page low 0x40, load page high 0x48, write page 0x4C, extended address 0x4D, read low 0x20, read high 0x28, EEPROM write 0xC0, EEPROM read 0xA0. Memory operation codes on `mem_op`: 0 none, 1 flash word write, 2 EEPROM byte erase, 3 EEPROM byte write, 4 erase all.

Top module: `spt_target`

## Requirements
- R1: After reset, `sdo` is 0, `busy` is 0 and `mem_op` is 0 (no operation).
- R2: Frames are four bytes, each shifted most significant bit first. Until the frame 0xAC,0x53,x,x has been received, every other frame is ignored. The output byte in slots 1 and 2 is 0x00, and so is the output byte in slot 4 for frames that return no data.
- R3: During slot 3 the output repeats the byte received in slot 2. A host whose framing is one byte out of step therefore does not see its second byte echoed.
- R4: When `prog_en_n` goes high, framing restarts at slot 1, the enabled state and the error flag are cleared, and commands are ignored until a new enable frame arrives.
- R5: Chip erase (0xAC,0x80,x,x) issues a single erase-all operation (code 4), after which `busy` stays high for exactly T_ERASE cycles.
- R6: Poll (0xF0,x,x,x) returns {6'b0, error, busy} in slot 4, sampled when byte 3 completes.
- R7: Load page low (0x40) and load page high (0x48) write byte 4 into word byte3[PW_LOG2-1:0] of the page buffer. A high byte is ignored unless a low byte has been loaded into that word since the word's last high byte. After reset every buffer word is 0xFFFF.
- R8: Write page (0x4C,a,b,x) issues PAGE_WORDS flash writes (code 1) at the ascending word addresses {ext, a, b} whose low PW_LOG2 bits are replaced by 0..PAGE_WORDS-1, with buffer word i as the data. `busy` stays high for exactly T_PAGE cycles.
- R9: Extended address (0x4D,x,e,x) stores e. The value is kept across later commands and across enable pulses, and it forms address bits 23:16 for page writes and reads.
- R10: Read low (0x20,a,b,x) and read high (0x28,a,b,x) return the low or high byte of flash word {ext,a,b} in slot 4.
- R11: EEPROM write (0xC0,a,b,d) issues an erase (code 2) followed by a write (code 3) of d at {a,b}, then stays busy for exactly T_EE cycles. EEPROM read (0xA0,a,b,x) returns the byte at {a,b} in slot 4.
- R12: A write-page, EEPROM write or chip erase frame that completes while `busy` is high issues no operation and sets the error flag. The flag stays set until `prog_en_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_en_n | input | 1 | Active-low programming enable from the host |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, changes on falling `sck` |
| mem_op | output | 3 | Memory operation code for this cycle |
| mem_addr | output | 24 | Word address (flash) or byte address in bits 15:0 (EEPROM) |
| mem_wdata | output | 16 | Write data; EEPROM uses bits 7:0 |
| mem_fl_rdata | input | 16 | Flash word at `mem_addr`, combinational |
| mem_ee_rdata | input | 8 | EEPROM byte at `mem_addr[15:0]`, combinational |
| busy | output | 1 | A write or erase is in progress |

## Verification
The assertions assume that the memory model returns read data combinationally from `mem_addr`. They also assume that the serial clock is slow enough for every synchronised edge to be handled before the next one, and that nothing outside the engine changes the page buffer while a page is being written. The bench holds every serial half period at six system clocks and always polls until the block is ready before it loads a new page or reads memory. The only frame it issues during a busy period is the one that deliberately provokes the error flag. Its memory model clears bits on writes, like real non-volatile cells, so a missing EEPROM erase shows up as corrupted data.

// File: rtl/spt_pkg.sv
// Shared codes for the serial programming target.
// Assumes: all frames are four bytes; command byte in slot 1.
package spt_pkg;
    localparam logic [7:0] OP_EN      = 8'hAC;
    localparam logic [7:0] KEY_EN     = 8'h53;
    localparam logic [7:0] KEY_ERASE  = 8'h80;
    localparam logic [7:0] OP_POLL    = 8'hF0;
    localparam logic [7:0] OP_LD_LO   = 8'h40;
    localparam logic [7:0] OP_LD_HI   = 8'h48;
    localparam logic [7:0] OP_WR_PAGE = 8'h4C;
    localparam logic [7:0] OP_EXT     = 8'h4D;
    localparam logic [7:0] OP_RD_LO   = 8'h20;
    localparam logic [7:0] OP_RD_HI   = 8'h28;
    localparam logic [7:0] OP_EE_WR   = 8'hC0;
    localparam logic [7:0] OP_EE_RD   = 8'hA0;

    typedef enum logic [2:0] {
        MOP_NONE     = 3'd0,
        MOP_FL_WR    = 3'd1,
        MOP_EE_ERASE = 3'd2,
        MOP_EE_WR    = 3'd3,
        MOP_ALL_ERASE = 3'd4
    } mem_op_e;

    typedef enum logic [1:0] {
        JOB_NONE  = 2'd0,
        JOB_ERASE = 2'd1,
        JOB_PAGE  = 2'd2,
        JOB_EE    = 2'd3
    } job_e;
endpackage

// File: rtl/spt_shift.sv
// Serial shifter: synchronises sck/sdi/enable into clk, frames bits into
// bytes (MSB first, sampled on rising sck), counts byte slots 0..3 and
// shifts the reply out on falling sck. Assumes sck half period >= 6 clk.
module spt_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_n,
    input  logic       sck,
    input  logic       sdi,
    input  logic       load_tx,
    input  logic [7:0] tx_byte,
    output logic       sdo,
    output logic       en_act,
    output logic       byte_done,
    output logic [1:0] byte_idx,
    output logic [7:0] rx_byte
);
    logic [2:0] sck_sy;
    logic [1:0] sdi_sy;
    logic [1:0] en_sy;
    logic [2:0] bit_cnt;
    logic [1:0] slot_cnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic       rise;
    logic       fall;

    // Bring the host signals into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sy <= '0;
            sdi_sy <= '0;
            en_sy  <= 2'b11;
        end else begin
            sck_sy <= {sck_sy[1:0], sck};
            sdi_sy <= {sdi_sy[0], sdi};
            en_sy  <= {en_sy[0], en_n};
        end
    end

    assign en_act = ~en_sy[1];
    assign rise   = sck_sy[1] & ~sck_sy[2];
    assign fall   = ~sck_sy[1] & sck_sy[2];

    // Bit and slot framing, receive and transmit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_act) begin
            bit_cnt   <= '0;
            slot_cnt  <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            byte_done <= 1'b0;
            byte_idx  <= '0;
            rx_byte   <= '0;
        end else begin
            byte_done <= 1'b0;
            if (rise) begin
                rx_sh <= {rx_sh[6:0], sdi_sy[1]};
                if (bit_cnt == 3'd7) begin
                    bit_cnt   <= '0;
                    byte_done <= 1'b1;
                    byte_idx  <= slot_cnt;
                    rx_byte   <= {rx_sh[6:0], sdi_sy[1]};
                    slot_cnt  <= slot_cnt + 2'd1;
                end else begin
                    bit_cnt <= bit_cnt + 3'd1;
                end
            end
            if (fall && bit_cnt != 3'd0) begin
                tx_sh <= {tx_sh[6:0], 1'b0};
            end
            if (load_tx) begin
                tx_sh <= tx_byte;
            end
        end
    end

    assign sdo = tx_sh[7];

    a_r2_done_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(rise));
    a_r4_idle_framing: assert property (@(posedge clk) disable iff (!rst_n)
        !en_act |=> !byte_done);
endmodule

// File: rtl/spt_pagebuf.sv
// Page buffer: PAGE_WORDS 16-bit words loaded a byte at a time. A high
// byte is only taken once the word's low byte has been loaded since its
// last high byte. Assumes one load per cycle at most.
module spt_pagebuf #(
    parameter int PW_LOG2 = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [PW_LOG2-1:0] wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [PW_LOG2-1:0] rd_idx,
    output logic [15:0]        rd_word
);
    localparam int PW = 1 << PW_LOG2;

    logic [PW*16-1:0] words_flat;

    for (genvar i = 0; i < PW; i++) begin : g_w
        logic [15:0] w;
        logic        lo_seen;
        logic        sel;

        assign sel = (wr_idx == PW_LOG2'(i));

        // One buffer word with its low-before-high ordering flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                w       <= 16'hFFFF;
                lo_seen <= 1'b0;
            end else if (wr_lo && sel) begin
                w[7:0]  <= wr_data;
                lo_seen <= 1'b1;
            end else if (wr_hi && sel && lo_seen) begin
                w[15:8] <= wr_data;
                lo_seen <= 1'b0;
            end
        end

        assign words_flat[i*16 +: 16] = w;

        a_r7_hi_needs_lo: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hi && !wr_lo && sel && !lo_seen) |=> $stable(w));
    end

    assign rd_word = words_flat[rd_idx*16 +: 16];
endmodule

// File: rtl/spt_engine.sv
// Job engine: accepts erase / page write / EEPROM write jobs, issues their
// memory operations one per cycle, and holds busy for a parameterised
// cycle count. Jobs offered while busy are dropped and set a sticky error.
// Assumes durations are at least the number of operations of the job.
module spt_engine
    import spt_pkg::*;
#(
    parameter int PW_LOG2 = 7,
    parameter int T_ERASE = 2000,
    parameter int T_PAGE  = 1000,
    parameter int T_EE    = 500
) (
    input  logic               clk,
    input  logic               rst_n,
    input  job_e               req,
    input  logic [23:0]        req_addr,
    input  logic [7:0]         req_data,
    input  logic               clr_err,
    input  logic [15:0]        buf_word,
    output logic [PW_LOG2-1:0] buf_idx,
    output logic               busy,
    output logic               err,
    output logic               issuing,
    output mem_op_e            op,
    output logic [23:0]        op_addr,
    output logic [15:0]        op_wdata
);
    localparam int PW      = 1 << PW_LOG2;
    localparam int D_ERASE = (T_ERASE < 1)  ? 1  : T_ERASE;
    localparam int D_PAGE  = (T_PAGE < PW)  ? PW : T_PAGE;
    localparam int D_EE    = (T_EE < 2)     ? 2  : T_EE;
    localparam int D_MAX   = (D_ERASE > D_PAGE) ? ((D_ERASE > D_EE) ? D_ERASE : D_EE)
                                                : ((D_PAGE > D_EE) ? D_PAGE : D_EE);
    localparam int CW      = $clog2(D_MAX + 1);
    localparam int SW      = PW_LOG2 + 1;

    job_e          job;
    logic [CW-1:0] cnt;
    logic [SW-1:0] step;
    logic [SW-1:0] n_steps;
    logic [23:0]   job_addr;
    logic [7:0]    job_data;

    // Number of memory operations the current job issues.
    always_comb begin
        case (job)
            JOB_ERASE: n_steps = SW'(1);
            JOB_PAGE:  n_steps = SW'(PW);
            JOB_EE:    n_steps = SW'(2);
            default:   n_steps = '0;
        endcase
    end

    // Job acceptance, busy countdown, operation stepping and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            job      <= JOB_NONE;
            cnt      <= '0;
            step     <= '0;
            busy     <= 1'b0;
            err      <= 1'b0;
            job_addr <= '0;
            job_data <= '0;
        end else begin
            if (clr_err) err <= 1'b0;
            if (req != JOB_NONE && busy) begin
                err <= 1'b1;
            end
            if (req != JOB_NONE && !busy) begin
                job      <= req;
                busy     <= 1'b1;
                step     <= '0;
                job_addr <= req_addr;
                job_data <= req_data;
                case (req)
                    JOB_ERASE: cnt <= CW'(D_ERASE);
                    JOB_PAGE:  cnt <= CW'(D_PAGE);
                    default:   cnt <= CW'(D_EE);
                endcase
            end else if (busy) begin
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) busy <= 1'b0;
                if (step < n_steps) step <= step + SW'(1);
            end
        end
    end

    assign issuing = busy && (step < n_steps);
    assign buf_idx = step[PW_LOG2-1:0];

    // Memory operation presented in this cycle.
    always_comb begin
        op       = MOP_NONE;
        op_addr  = job_addr;
        op_wdata = 16'h0000;
        if (issuing) begin
            case (job)
                JOB_ERASE: op = MOP_ALL_ERASE;
                JOB_PAGE: begin
                    op       = MOP_FL_WR;
                    op_addr  = {job_addr[23:PW_LOG2], step[PW_LOG2-1:0]};
                    op_wdata = buf_word;
                end
                JOB_EE: begin
                    op       = (step == '0) ? MOP_EE_ERASE : MOP_EE_WR;
                    op_addr  = {8'h00, job_addr[15:0]};
                    op_wdata = {8'h00, job_data};
                end
                default: op = MOP_NONE;
            endcase
        end
    end

    a_r8_addr_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        (op == MOP_FL_WR && $past(op) == MOP_FL_WR) |-> op_addr == $past(op_addr) + 24'd1);
    a_r11_erase_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op == MOP_EE_ERASE) |=> (op == MOP_EE_WR));
    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr_err) |=> err);
    a_r12_busy_drops_job: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req != JOB_NONE) |=> $stable(job));
    a_r5_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req != JOB_NONE) |=> busy);
endmodule

// File: rtl/spt_target.sv
// Serial programming target top: collects the four bytes of each frame,
// gates commands on the enable handshake, builds the reply byte for each
// slot, keeps the extended address and dispatches jobs to the engine.
// Assumes memory read data is combinational from mem_addr.
module spt_target
    import spt_pkg::*;
#(
    parameter int PW_LOG2 = 7,
    parameter int T_ERASE = 2000,
    parameter int T_PAGE  = 1000,
    parameter int T_EE    = 500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        prog_en_n,
    input  logic        sck,
    input  logic        sdi,
    output logic        sdo,
    output logic [2:0]  mem_op,
    output logic [23:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_fl_rdata,
    input  logic [7:0]  mem_ee_rdata,
    output logic        busy
);
    logic        en_act;
    logic        byte_done;
    logic [1:0]  byte_idx;
    logic [7:0]  rx_byte;
    logic        pend;
    logic [1:0]  pend_idx;
    logic [7:0]  b1, b2, b3, b4;
    logic [7:0]  ext;
    logic        enabled;
    logic [7:0]  tx_byte;
    logic        exec;
    job_e        req;
    logic        buf_lo, buf_hi;
    logic [15:0] buf_word;
    logic [PW_LOG2-1:0] buf_idx;
    logic        err;
    logic        issuing;
    mem_op_e     op;
    logic [23:0] op_addr;
    logic [23:0] frame_addr;

    spt_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_n      (prog_en_n),
        .sck       (sck),
        .sdi       (sdi),
        .load_tx   (pend),
        .tx_byte   (tx_byte),
        .sdo       (sdo),
        .en_act    (en_act),
        .byte_done (byte_done),
        .byte_idx  (byte_idx),
        .rx_byte   (rx_byte)
    );

    // Capture frame bytes and flag the following cycle for processing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0; pend_idx <= '0;
            b1 <= '0; b2 <= '0; b3 <= '0; b4 <= '0;
        end else begin
            pend <= byte_done;
            if (byte_done) begin
                pend_idx <= byte_idx;
                case (byte_idx)
                    2'd0:    b1 <= rx_byte;
                    2'd1:    b2 <= rx_byte;
                    2'd2:    b3 <= rx_byte;
                    default: b4 <= rx_byte;
                endcase
            end
        end
    end

    // Enable handshake state and the persistent extended address byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enabled <= 1'b0;
            ext     <= '0;
        end else if (!en_act) begin
            enabled <= 1'b0;
        end else if (pend && pend_idx == 2'd3) begin
            if (!enabled && b1 == OP_EN && b2 == KEY_EN) enabled <= 1'b1;
            if (enabled && b1 == OP_EXT) ext <= b3;
        end
    end

    assign exec       = en_act && enabled && pend && (pend_idx == 2'd3);
    assign frame_addr = {ext, b2, b3};

    // Decode the completed frame into a job or a buffer load.
    always_comb begin
        req    = JOB_NONE;
        buf_lo = 1'b0;
        buf_hi = 1'b0;
        if (exec) begin
            case (b1)
                OP_EN:      if (b2 == KEY_ERASE) req = JOB_ERASE;
                OP_WR_PAGE: req = JOB_PAGE;
                OP_EE_WR:   req = JOB_EE;
                OP_LD_LO:   buf_lo = 1'b1;
                OP_LD_HI:   buf_hi = 1'b1;
                default:    req = JOB_NONE;
            endcase
        end
    end

    // Reply byte for the next slot.
    always_comb begin
        tx_byte = 8'h00;
        if (pend_idx == 2'd1) begin
            tx_byte = b2;
        end else if (pend_idx == 2'd2 && enabled) begin
            case (b1)
                OP_RD_LO: tx_byte = mem_fl_rdata[7:0];
                OP_RD_HI: tx_byte = mem_fl_rdata[15:8];
                OP_EE_RD: tx_byte = mem_ee_rdata;
                OP_POLL:  tx_byte = {6'b0, err, busy};
                default:  tx_byte = 8'h00;
            endcase
        end
    end

    spt_pagebuf #(.PW_LOG2(PW_LOG2)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (buf_lo),
        .wr_hi   (buf_hi),
        .wr_idx  (b3[PW_LOG2-1:0]),
        .wr_data (b4),
        .rd_idx  (buf_idx),
        .rd_word (buf_word)
    );

    spt_engine #(
        .PW_LOG2 (PW_LOG2),
        .T_ERASE (T_ERASE),
        .T_PAGE  (T_PAGE),
        .T_EE    (T_EE)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_addr (frame_addr),
        .req_data (b4),
        .clr_err  (!en_act),
        .buf_word (buf_word),
        .buf_idx  (buf_idx),
        .busy     (busy),
        .err      (err),
        .issuing  (issuing),
        .op       (op),
        .op_addr  (op_addr),
        .op_wdata (mem_wdata)
    );

    assign mem_op   = op;
    assign mem_addr = issuing ? op_addr : frame_addr;

    a_r4_no_job_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled) |-> (req == JOB_NONE && !buf_lo && !buf_hi));
    a_r9_ext_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend && pend_idx == 2'd3) |=> $stable(ext));
endmodule

// File: tb/spt_target_bench.sv
// Bench for spt_target: small page, serial host tasks, bit-clearing memory.
module spt_target_bench;
    import spt_pkg::*;

    localparam int PW_LOG2 = 3;
    localparam int PW      = 1 << PW_LOG2;
    localparam int T_ERASE = 900;
    localparam int T_PAGE  = 600;
    localparam int T_EE    = 500;
    localparam int HALF    = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_en_n = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic [2:0]  mem_op;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_fl_rdata;
    logic [7:0]  mem_ee_rdata;
    logic        busy;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [15:0] fl_mem [1024];
    logic [7:0]  ee_mem [256];
    int n_fl = 0, n_eeer = 0, n_eewr = 0, n_all = 0;
    int run_len = 0, last_len = 0;
    logic [23:0] first_fl_addr = '0;
    logic [2:0]  prev_op = '0;

    always #10 clk = ~clk;

    spt_target #(
        .PW_LOG2 (PW_LOG2),
        .T_ERASE (T_ERASE),
        .T_PAGE  (T_PAGE),
        .T_EE    (T_EE)
    ) u_spt_target (
        .clk          (clk),
        .rst_n        (rst_n),
        .prog_en_n    (prog_en_n),
        .sck          (sck),
        .sdi          (sdi),
        .sdo          (sdo),
        .mem_op       (mem_op),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_fl_rdata (mem_fl_rdata),
        .mem_ee_rdata (mem_ee_rdata),
        .busy         (busy)
    );

    assign mem_fl_rdata = fl_mem[{mem_addr[17:16], mem_addr[7:0]}];
    assign mem_ee_rdata = ee_mem[mem_addr[7:0]];

    // Memory model: writes only clear bits; erases set them.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) fl_mem[i] = 16'hFFFF;
            for (int i = 0; i < 256; i++) ee_mem[i] = 8'hFF;
        end else begin
            if (busy) run_len++;
            else if (run_len != 0) begin last_len = run_len; run_len = 0; end
            case (mem_op)
                3'd1: begin
                    if (prev_op != 3'd1) first_fl_addr = mem_addr;
                    fl_mem[{mem_addr[17:16], mem_addr[7:0]}] &= mem_wdata;
                    n_fl++;
                end
                3'd2: begin ee_mem[mem_addr[7:0]] = 8'hFF; n_eeer++; end
                3'd3: begin ee_mem[mem_addr[7:0]] &= mem_wdata[7:0]; n_eewr++; end
                3'd4: begin
                    for (int i = 0; i < 1024; i++) fl_mem[i] = 16'hFFFF;
                    for (int i = 0; i < 256; i++) ee_mem[i] = 8'hFF;
                    n_all++;
                end
                default: ;
            endcase
            prev_op = mem_op;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int k = 7; k >= 0; k--) begin
            @(negedge clk);
            sdi = tx[k];
            repeat (HALF) @(negedge clk);
            rx[k] = sdo;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] c, input logic [7:0] d,
                        output logic [31:0] r);
        logic [7:0] t;
        xbyte(a, t); r[31:24] = t;
        xbyte(b, t); r[23:16] = t;
        xbyte(c, t); r[15:8]  = t;
        xbyte(d, t); r[7:0]   = t;
    endtask

    task automatic en_pulse();
        @(negedge clk);
        prog_en_n = 1'b1;
        repeat (10) @(negedge clk);
        prog_en_n = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic wait_ready(output logic [7:0] first, output logic [7:0] last);
        logic [31:0] r;
        xfer(8'hF0, 8'h00, 8'h00, 8'h00, r);
        first = r[7:0];
        last = r[7:0];
        for (int n = 0; n < 40 && last[0]; n++) begin
            xfer(8'hF0, 8'h00, 8'h00, 8'h00, r);
            last = r[7:0];
        end
    endtask

    function automatic logic [15:0] pat(input int p, input int i);
        return 16'(p * 16'h1000 + i * 16'h0111 + 16'h0203);
    endfunction

    task automatic read_word(input logic [7:0] a, input logic [7:0] b, output logic [15:0] w);
        logic [31:0] r;
        xfer(8'h20, a, b, 8'h00, r); w[7:0] = r[7:0];
        xfer(8'h28, a, b, 8'h00, r); w[15:8] = r[7:0];
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  f, l;
        logic [15:0] w, e;
        int base;

        repeat (10) @(negedge clk);
        chk(sdo == 1'b0, "R1 sdo after reset", sdo, 0);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(mem_op == 3'd0, "R1 mem_op after reset", mem_op, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        prog_en_n = 1'b0;
        repeat (10) @(negedge clk);

        // R2: commands before enable are ignored.
        xfer(8'hC0, 8'h00, 8'h05, 8'h00, r);
        repeat (20) @(negedge clk);
        chk(n_eeer == 0 && n_eewr == 0, "R2 write before enable", n_eeer + n_eewr, 0);

        // R3: enable frame echoes 0x53; R2 other slots are zero.
        xfer(8'hAC, 8'h53, 8'h00, 8'h00, r);
        chk(r[15:8] == 8'h53, "R3 enable echo", r[15:8], 8'h53);
        chk(r[31:16] == 16'h0000, "R2 slot1/2 output", r[31:16], 0);
        chk(r[7:0] == 8'h00, "R2 slot4 output", r[7:0], 0);

        xfer(8'hA0, 8'h00, 8'h05, 8'h00, r);
        chk(r[7:0] == 8'hFF, "R2 ignored EEPROM write", r[7:0], 8'hFF);
        xfer(8'h20, 8'h5A, 8'h00, 8'h00, r);
        chk(r[15:8] == 8'h5A, "R3 echo of byte 2", r[15:8], 8'h5A);

        // R11 and R6: EEPROM write, auto-erase on overwrite.
        xfer(8'hC0, 8'h00, 8'h05, 8'h3C, r);
        wait_ready(f, l);
        chk(f[0] == 1'b1, "R6 poll busy after EEPROM write", f, 1);
        chk(l[0] == 1'b0, "R6 poll ready", l, 0);
        chk(last_len == T_EE, "R11 EEPROM busy length", last_len, T_EE);
        chk(n_eeer == 1 && n_eewr == 1, "R11 erase and write ops", n_eeer * 16 + n_eewr, 8'h11);
        xfer(8'hA0, 8'h00, 8'h05, 8'h00, r);
        chk(r[7:0] == 8'h3C, "R11 EEPROM read back", r[7:0], 8'h3C);
        xfer(8'hC0, 8'h00, 8'h05, 8'hC3, r);
        wait_ready(f, l);
        xfer(8'hA0, 8'h00, 8'h05, 8'h00, r);
        chk(r[7:0] == 8'hC3, "R11 overwrite needs erase", r[7:0], 8'hC3);

        // R7/R8/R10: load a page (word 3 gets high byte first), write at ext 01.
        xfer(8'h4D, 8'h00, 8'h01, 8'h00, r);
        for (int i = 0; i < PW; i++) begin
            w = pat(1, i);
            if (i == 3) xfer(8'h48, 8'h00, 8'(i), 8'hAA, r);
            xfer(8'h40, 8'h00, 8'(i), w[7:0], r);
            if (i != 3) xfer(8'h48, 8'h00, 8'(i), w[15:8], r);
        end
        base = n_fl;
        xfer(8'h4C, 8'h23, 8'h45, 8'h00, r);
        wait_ready(f, l);
        chk(f[0] == 1'b1, "R6 poll busy after page write", f, 1);
        chk(last_len == T_PAGE, "R8 page busy length", last_len, T_PAGE);
        chk(n_fl - base == PW, "R8 page word count", n_fl - base, PW);
        chk(first_fl_addr == 24'h012340, "R8 page base address", first_fl_addr, 24'h012340);
        for (int i = 0; i < PW; i++) begin
            read_word(8'h23, 8'(8'h40 + i), w);
            e = (i == 3) ? {8'hFF, pat(1, i) & 16'h00FF} | 16'hFF00 : pat(1, i);
            chk(w == e, (i == 3) ? "R7 high before low ignored" : "R10 read page word", w, e);
        end

        // R9: second page at ext 02, then switch back.
        xfer(8'h4D, 8'h00, 8'h02, 8'h00, r);
        for (int i = 0; i < PW; i++) begin
            w = pat(2, i);
            xfer(8'h40, 8'h00, 8'(i), w[7:0], r);
            xfer(8'h48, 8'h00, 8'(i), w[15:8], r);
        end
        xfer(8'h4C, 8'h23, 8'h40, 8'h00, r);
        wait_ready(f, l);
        chk(first_fl_addr == 24'h022340, "R9 ext used by page write", first_fl_addr, 24'h022340);
        read_word(8'h23, 8'h46, w);
        chk(w == pat(2, 6), "R9 read with ext 02", w, pat(2, 6));
        xfer(8'h4D, 8'h00, 8'h01, 8'h00, r);
        read_word(8'h23, 8'h40, w);
        chk(w == pat(1, 0), "R9 read with ext 01", w, pat(1, 0));

        // R4: enable pulse drops state; ext persists (R9).
        en_pulse();
        xfer(8'hC0, 8'h00, 8'h06, 8'h11, r);
        xfer(8'hAC, 8'h53, 8'h00, 8'h00, r);
        chk(r[15:8] == 8'h53, "R4 re-enable echo", r[15:8], 8'h53);
        xfer(8'hA0, 8'h00, 8'h06, 8'h00, r);
        chk(r[7:0] == 8'hFF, "R4 command ignored after pulse", r[7:0], 8'hFF);
        read_word(8'h23, 8'h41, w);
        chk(w == pat(1, 1), "R9 ext kept across pulse", w, pat(1, 1));

        // R12: job while busy ignored, sticky error.
        base = n_eewr;
        xfer(8'h4C, 8'h23, 8'h40, 8'h00, r);
        xfer(8'hC0, 8'h00, 8'h07, 8'h22, r);
        wait_ready(f, l);
        chk(f[1] == 1'b1, "R12 error flag set", f, 2);
        chk(l[1] == 1'b1, "R12 error flag sticky", l, 2);
        chk(n_eewr == base, "R12 no op while busy", n_eewr - base, 0);
        xfer(8'hA0, 8'h00, 8'h07, 8'h00, r);
        chk(r[7:0] == 8'hFF, "R12 EEPROM untouched", r[7:0], 8'hFF);
        en_pulse();
        xfer(8'hAC, 8'h53, 8'h00, 8'h00, r);
        xfer(8'hF0, 8'h00, 8'h00, 8'h00, r);
        chk(r[7:0] == 8'h00, "R4 error cleared by pulse", r[7:0], 0);

        // R3/R4: a stray byte breaks the echo; a pulse restores it.
        xbyte(8'hFF, f);
        xfer(8'hAC, 8'h53, 8'h00, 8'h00, r);
        chk(r[15:8] != 8'h53, "R3 misaligned echo", r[15:8], 8'h00);
        xbyte(8'hAC, f);
        xbyte(8'h53, f);
        en_pulse();
        xfer(8'hAC, 8'h53, 8'h00, 8'h00, r);
        chk(r[15:8] == 8'h53, "R4 resync after pulse", r[15:8], 8'h53);

        // R5: chip erase.
        xfer(8'hAC, 8'h80, 8'h00, 8'h00, r);
        wait_ready(f, l);
        chk(n_all == 1, "R5 single erase op", n_all, 1);
        chk(last_len == T_ERASE, "R5 erase busy length", last_len, T_ERASE);
        read_word(8'h23, 8'h42, w);
        chk(w == 16'hFFFF, "R5 flash erased", w, 16'hFFFF);
        xfer(8'hA0, 8'h00, 8'h05, 8'h00, r);
        chk(r[7:0] == 8'hFF, "R5 EEPROM erased", r[7:0], 8'hFF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule